// File: doc/BRIEF.md
# Flash Controller Status and Interrupt Register Slice

This block holds the status and interrupt-control state of a flash memory controller. The controller's sequencer and data path report events as single-cycle set pulses: controller ready, flash ready, page finished and command finished per chip select, bad block found per chip select, correctable and uncorrectable ECC errors, and three transfer requests. Each pulse latches into a sticky status bit. Software clears a status bit by writing one to it. A mask field in the control register selects which status sources may raise the single level-sensitive interrupt line.

The control register also carries a run bit. Software sets the run bit to start a command. The sequencer clears it through a completion strobe. If software writes the run bit to zero while a command is in flight, the block pulses an abort strobe so that the sequencer returns to idle. When the controller clock has been gated off and is restored, a restore strobe loads a fixed status pattern. In that pattern both ready bits are set and every other bit is clear.

Software reaches both registers through one register port. A 1-bit address selects control (0) or status (1). Writes are strobed, and read data is a combinational function of the address and the current state.

Top module: `flash_stat_irq`

## Requirements
- R1: After synchronous reset the status reads 0x0000, the control register reads 0x00000FFF (all twelve masks set, run bit 0), and irq_o and abort_o are low.
- R2: A pulse on ev_set[i] sets status bit i at the next clock edge. The status bit map is: 12 controller ready, 11 flash ready, 10/9 page done for chip select 0/1, 8/7 command done for chip select 0/1, 6/5 bad block for chip select 0/1, 4 uncorrectable error, 3 corrected error, 2 write-data request, 1 read-data request, 0 write-command request.
- R3: A write to address 1 clears every status bit whose data bit (bits 12:0) is 1 and leaves every bit written with 0 unchanged. Writing 0xFFF clears bits 11:0 and keeps bit 12.
- R4: When a set pulse and a software clear hit the same status bit in the same cycle, the bit stays set.
- R5: A write to address 0 loads the mask field from data bits 11:0, and the mask reads back at bits 11:0 of address 0.
- R6: irq_o is high exactly when some status bit i in 11:0 is 1 while mask bit i is 0. Status bit 12 never raises irq_o.
- R7: A write to address 0 with data bit 28 equal to 1 sets the run bit at the next edge. run_o follows the run bit, and the run bit reads back at bit 28 of address 0.
- R8: A run_done pulse clears the run bit at the next edge. A software write to address 0 in the same cycle takes precedence over run_done.
- R9: A write to address 0 with bit 28 equal to 0 while the run bit is 1 and run_done is low clears the run bit. It also raises abort_o for exactly the one cycle after that edge. Such a write in any other situation leaves abort_o low.
- R10: A clk_restore pulse loads status with 0x1800 at the next edge. This overrides set pulses and software clears in the same cycle.
- R11: Control bits other than 28 and 11:0 read as 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ev_set | input | 13 | Status set pulses, one per status bit |
| run_done | input | 1 | Sequencer completion; clears the run bit |
| clk_restore | input | 1 | Clock-restored event; forces status to 0x1800 |
| run_o | output | 1 | Current run bit |
| abort_o | output | 1 | One-cycle abort request to the sequencer |
| irq_o | output | 1 | Level interrupt from unmasked status bits 11:0 |

## Verification
The bench drives a set pulse and a clear of the same bit in the same cycle. A design that gives the clear precedence would lose a status event silently. It checks that bit 12 never raises the interrupt and that a single masked source stays quiet while a neighbouring unmasked source does raise it. Getting either of these wrong would show as a spurious interrupt or a dead source. The restore strobe is applied together with a set pulse and a clear to confirm that the forced 0x1800 wins. The run bit is exercised with completion and software writes arriving in the same cycle, including a stop write that meets completion. A wrong design would either leave the run bit stuck or issue an abort for a command that had already finished.

// File: rtl/fsi_pkg.sv
`timescale 1ns/1ps
// Shared constants for the flash status / interrupt register slice.
// Assumes RUN_POS lies above the status width and below the data width.
package fsi_pkg;
    localparam int FSI_DATA_W  = 32;
    localparam int FSI_STAT_W  = 13;
    localparam int FSI_SRC_W   = 12;
    localparam int FSI_RUN_POS = 28;

    // Status bit positions that carry behaviour (restore pattern)
    localparam int FSI_B_CTRL_RDY  = 12;
    localparam int FSI_B_FLASH_RDY = 11;

    // Register select codes
    localparam logic FSI_SEL_CTRL = 1'b0;
    localparam logic FSI_SEL_STAT = 1'b1;
endpackage

// File: rtl/fsi_stat_bank.sv
`timescale 1ns/1ps
// Sticky status bank: one flop per bit with set, write-one-to-clear and a
// forced load. Priority per bit: force > set > clear.
// Assumes set and clear arrive as single-cycle qualified strobes.
module fsi_stat_bank #(
    parameter int             W       = 13,
    parameter logic [W-1:0]   FORCE_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic         force_i,
    output logic [W-1:0] stat_o
);
    for (genvar i = 0; i < W; i++) begin : g_cell
        logic q;
        // Purpose: hold one status bit with force/set/clear priority
        always_ff @(posedge clk) begin
            if (!rst_n)          q <= 1'b0;
            else if (force_i)    q <= FORCE_V[i];
            else if (set_i[i])   q <= 1'b1;
            else if (clr_i[i])   q <= 1'b0;
        end
        assign stat_o[i] = q;
    end
endmodule

// File: rtl/fsi_ctrl_reg.sv
`timescale 1ns/1ps
// Control state: interrupt mask field (1 = source disabled) and run bit.
// Software writes take precedence over completion; a stop write on a
// running command that is not completing in the same cycle yields a
// registered one-cycle abort.
module fsi_ctrl_reg #(
    parameter int SRC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SRC_W-1:0] mask_wdata_i,
    input  logic             run_wdata_i,
    input  logic             run_done_i,
    output logic [SRC_W-1:0] mask_o,
    output logic             run_o,
    output logic             abort_o
);
    logic [SRC_W-1:0] mask_q;
    logic             run_q;
    logic             abort_q;

    // Purpose: mask field, reset to all sources disabled
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '1;
        else if (wr_i) mask_q <= mask_wdata_i;
    end

    // Purpose: run bit, set/cleared by software, cleared by completion
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (wr_i)       run_q <= run_wdata_i;
        else if (run_done_i) run_q <= 1'b0;
    end

    // Purpose: one-cycle abort when software stops a live command
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= wr_i && !run_wdata_i && run_q && !run_done_i;
    end

    assign mask_o  = mask_q;
    assign run_o   = run_q;
    assign abort_o = abort_q;
endmodule

// File: rtl/fsi_irq_merge.sv
`timescale 1ns/1ps
// Folds maskable status sources into one level interrupt.
// A mask bit of 1 blocks its source.
module fsi_irq_merge #(
    parameter int SRC_W = 12
) (
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic             irq_o
);
    // Purpose: OR of all enabled, pending sources
    always_comb begin
        irq_o = |(src_i & ~mask_i);
    end
endmodule

// File: rtl/flash_stat_irq.sv
`timescale 1ns/1ps
// Top of the status / interrupt register slice. Decodes the register port,
// routes set pulses and clears into the status bank, holds control state
// and forms the interrupt. Read data is combinational from state.
// Assumes STAT_W = SRC_W + 1 and STAT_W < RUN_POS < DATA_W - 1.
module flash_stat_irq
    import fsi_pkg::*;
#(
    parameter int DATA_W  = FSI_DATA_W,
    parameter int STAT_W  = FSI_STAT_W,
    parameter int SRC_W   = FSI_SRC_W,
    parameter int RUN_POS = FSI_RUN_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [STAT_W-1:0] ev_set,
    input  logic              run_done,
    input  logic              clk_restore,
    output logic              run_o,
    output logic              abort_o,
    output logic              irq_o
);
    localparam logic [STAT_W-1:0] RESTORE_V =
        STAT_W'((1 << FSI_B_CTRL_RDY) | (1 << FSI_B_FLASH_RDY));

    logic              wr_ctrl;
    logic              wr_stat;
    logic [STAT_W-1:0] stat_clr;
    logic [STAT_W-1:0] stat_q;
    logic [SRC_W-1:0]  mask_q;
    logic              unused_wdata;

    assign wr_ctrl  = reg_wr && (reg_addr == FSI_SEL_CTRL);
    assign wr_stat  = reg_wr && (reg_addr == FSI_SEL_STAT);
    assign stat_clr = wr_stat ? reg_wdata[STAT_W-1:0] : '0;
    assign unused_wdata = ^{reg_wdata[DATA_W-1:RUN_POS+1],
                            reg_wdata[RUN_POS-1:STAT_W]};

    fsi_stat_bank #(.W(STAT_W), .FORCE_V(RESTORE_V)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (ev_set),
        .clr_i   (stat_clr),
        .force_i (clk_restore),
        .stat_o  (stat_q)
    );

    fsi_ctrl_reg #(.SRC_W(SRC_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctrl),
        .mask_wdata_i (reg_wdata[SRC_W-1:0]),
        .run_wdata_i  (reg_wdata[RUN_POS]),
        .run_done_i   (run_done),
        .mask_o       (mask_q),
        .run_o        (run_o),
        .abort_o      (abort_o)
    );

    fsi_irq_merge #(.SRC_W(SRC_W)) u_irq (
        .src_i  (stat_q[SRC_W-1:0]),
        .mask_i (mask_q),
        .irq_o  (irq_o)
    );

    // Purpose: read mux for the two registers, unused bits read as zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == FSI_SEL_STAT) begin
            reg_rdata[STAT_W-1:0] = stat_q;
        end else begin
            reg_rdata[SRC_W-1:0] = mask_q;
            reg_rdata[RUN_POS]   = run_o;
        end
    end
endmodule

// File: rtl/fsi_chk.sv
`timescale 1ns/1ps
// Property checker for flash_stat_irq, attached by bind below.
module fsi_chk #(
    parameter int DATA_W  = 32,
    parameter int STAT_W  = 13,
    parameter int SRC_W   = 12,
    parameter int RUN_POS = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] ev_set,
    input logic              run_done,
    input logic              clk_restore,
    input logic [STAT_W-1:0] stat,
    input logic [SRC_W-1:0]  mask,
    input logic              run_o,
    input logic              abort_o,
    input logic              irq_o
);
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_set) && !clk_restore) |=> ((stat & $past(ev_set)) == $past(ev_set))); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && !clk_restore)
        |=> ((stat & $past(reg_wdata[STAT_W-1:0] & ~ev_set)) == '0)); // R3

    AST_RESTORE_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_restore |=> (stat == STAT_W'(13'h1800))); // R10

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o); // R6

    AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|stat[SRC_W-1:0])); // R6

    AST_RUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_addr && reg_wdata[RUN_POS]) |=> run_o); // R7

    AST_RUN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !(reg_wr && !reg_addr)) |=> !run_o); // R8

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !run_o); // R9

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R9
endmodule

bind flash_stat_irq fsi_chk #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .SRC_W(SRC_W), .RUN_POS(RUN_POS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .ev_set      (ev_set),
    .run_done    (run_done),
    .clk_restore (clk_restore),
    .stat        (stat_q),
    .mask        (mask_q),
    .run_o       (run_o),
    .abort_o     (abort_o),
    .irq_o       (irq_o)
);

// File: tb/flash_stat_irq_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one cycle of stimulus and pushes the
// values expected just after that cycle's clock edge; the monitor pops and
// compares them 1 ns after each rising edge.
module flash_stat_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] ev_set = '0;
    logic        run_done = 1'b0;
    logic        clk_restore = 1'b0;
    logic        run_o, abort_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 run, 3 abort
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    flash_stat_irq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
        .run_done(run_done), .clk_restore(clk_restore), .run_o(run_o),
        .abort_o(abort_o), .irq_o(irq_o)
    );

    // Driver: one cycle of stimulus
    task automatic step(input logic wr, input logic addr, input logic [31:0] wd,
                        input logic [12:0] set, input logic done, input logic rst_ev);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        ev_set = set; run_done = done; clk_restore = rst_ev;
    endtask

    task automatic expect_v(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare queued expectations after each edge
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = {31'b0, irq_o};
                2:       act = {31'b0, run_o};
                default: act = {31'b0, abort_o};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0);
        expect_v(0, 32'h0000_0FFF, "R1 ctrl reset");
        expect_v(1, 0, "R1 irq reset");
        expect_v(2, 0, "R1 run reset");
        expect_v(3, 0, "R1 abort reset");
        step(0, 1, 0, 0, 0, 0);
        expect_v(0, 0, "R1 status reset");
        // R2 set pulse on corrected-error bit 3
        step(0, 1, 0, 13'h008, 0, 0);
        expect_v(0, 32'h008, "R2 set bit3");
        expect_v(1, 0, "R6 masked after reset");
        // R5 unmask all
        step(1, 0, 0, 0, 0, 0);
        expect_v(0, 0, "R5 mask readback");
        expect_v(1, 1, "R6 irq unmasked");
        // R3 write zero keeps, write one clears
        step(1, 1, 0, 0, 0, 0);
        expect_v(0, 32'h008, "R3 write0 keeps");
        step(1, 1, 32'h008, 0, 0, 0);
        expect_v(0, 0, "R3 write1 clears");
        expect_v(1, 0, "R6 irq drops");
        // R6 bit 12 never interrupts
        step(0, 1, 0, 13'h1000, 0, 0);
        expect_v(0, 32'h1000, "R2 set bit12");
        expect_v(1, 0, "R6 bit12 no irq");
        // R6 single masked source
        step(1, 0, 32'h020, 0, 0, 0);
        expect_v(0, 32'h020, "R5 mask bit5");
        step(0, 1, 0, 13'h020, 0, 0);
        expect_v(0, 32'h1020, "R2 set bit5");
        expect_v(1, 0, "R6 bit5 masked");
        step(0, 1, 0, 13'h001, 0, 0);
        expect_v(0, 32'h1021, "R2 set bit0");
        expect_v(1, 1, "R6 bit0 unmasked");
        // R4 set beats clear
        step(1, 1, 32'h080, 13'h080, 0, 0);
        expect_v(0, 32'h10A1, "R4 set wins");
        // R3 0xFFF keeps bit 12
        step(1, 1, 32'hFFF, 0, 0, 0);
        expect_v(0, 32'h1000, "R3 fff keeps bit12");
        expect_v(1, 0, "R6 cleared no irq");
        // R10 restore overrides set and clear
        step(1, 1, 32'h1000, 13'h001, 0, 1);
        expect_v(0, 32'h1800, "R10 restore value");
        expect_v(1, 1, "R10 flash ready irq");
        step(1, 1, 32'h1FFF, 0, 0, 0);
        expect_v(0, 0, "R3 clear all");
        // R7 run set
        step(1, 0, 32'h1000_0FFF, 0, 0, 0);
        expect_v(0, 32'h1000_0FFF, "R7 run readback");
        expect_v(2, 1, "R7 run_o");
        expect_v(3, 0, "R7 no abort");
        // R8 completion clears
        step(0, 0, 0, 0, 1, 0);
        expect_v(0, 32'h0000_0FFF, "R8 done clears");
        expect_v(2, 0, "R8 run_o low");
        expect_v(3, 0, "R8 no abort on done");
        // R8 software set beats done
        step(1, 0, 32'h1000_0FFF, 0, 1, 0);
        expect_v(2, 1, "R8 sw set wins");
        // R9 abort
        step(1, 0, 32'h0000_0FFF, 0, 0, 0);
        expect_v(3, 1, "R9 abort pulse");
        expect_v(2, 0, "R9 run cleared");
        step(0, 0, 0, 0, 0, 0);
        expect_v(3, 0, "R9 abort one cycle");
        step(1, 0, 32'h0000_0FFF, 0, 0, 0);
        expect_v(3, 0, "R9 stop when idle");
        step(1, 0, 32'h1000_0FFF, 0, 0, 0);
        expect_v(2, 1, "R7 run again");
        step(1, 0, 32'h0000_0FFF, 0, 1, 0);
        expect_v(3, 0, "R9 stop with done");
        expect_v(2, 0, "R9 run low");
        // R11 unused control bits
        step(1, 0, 32'hE7FF_F555, 0, 0, 0);
        expect_v(0, 32'h0000_0555, "R11 unused bits zero");
        expect_v(2, 0, "R11 run untouched");
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule